// File: doc/BRIEF.md
# Carry-Select Adder/Subtractor Slice

This block adds or subtracts two W-bit operands (10 bits by default) with a carry-select structure. The slice is split into equal groups (two groups of five bits by default). Inside a group, every bit cell works out two answers in parallel: its sum and carry-out for an incoming carry of 0, and for an incoming carry of 1. Two candidate carry chains therefore run side by side through the group. The real carry entering a group then picks one of the two precomputed chains for that group's sum bits and for its carry-out. So the only carry that ripples through the whole slice is the one carry per group boundary.

A single mode input switches the whole slice between addition and subtraction. Subtraction reuses the adder: every B bit is inverted and the carry into the least significant cell is forced to 1. The carry-in port acts as a borrow-in when subtracting, and the carry-out port acts as a borrow-out. Because of this, slices chain the same way in both modes: a wide operation runs one word at a time, and each word's carry-out feeds the next word's carry-in.

The sum bits and the carry-out can leave the block straight from the logic, or through a register with a synchronous active-high reset when the slice is used as an accumulator stage. A parameter makes that choice, and the registered form is the default.

Top module: `csa_slice`

## Requirements
- R1: With sub=0, {carry_out, sum} equals op_a + op_b + carry_in as a (W+1)-bit unsigned value.
- R2: With sub=1, sum equals (op_a - op_b - carry_in) mod 2^W. carry_out is the borrow: it is 1 exactly when op_a < op_b + carry_in, compared as unsigned values.
- R3: With sub=1 and carry_in=0, subtraction forces a carry of 1 into the least significant cell. So op_a == op_b gives sum 0 and carry_out 0, for any value.
- R4: A carry that starts in the low group reaches the high group and the carry-out. For example 0x01F + 0x001 = 0x020, and 0x3FF + 0x001 = 0x000 with carry_out 1.
- R5: With REG_OUT=1 (the default), the result of the inputs present at a rising clock edge appears on sum and carry_out after that edge, and does not appear before it.
- R6: With REG_OUT=1, rst=1 at a rising edge clears sum and carry_out to 0 on that edge.
- R7: Cascading works through carry_out to carry_in in both modes. Two word steps, low word first, give the correct 2W-bit sum or difference, with the final carry or borrow.
- R8: The most negative value (bit W-1 set, all others clear) is handled: 0x200 - 0x001 = 0x1FF with borrow 0, and 0x000 - 0x200 = 0x200 with borrow 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | W | First operand |
| op_b | input | W | Second operand (the subtrahend when sub=1) |
| carry_in | input | 1 | Carry-in when adding, borrow-in when subtracting |
| sub | input | 1 | 0 selects A+B, 1 selects A-B |
| sum | output | W | Sum or difference |
| carry_out | output | 1 | Carry-out when adding, borrow-out when subtracting |

## Verification
The bench goes after carries that must cross the group boundary (0x01F+1, all ones plus one). A slice that selects with the wrong group carry-in would leave the upper five bits unchanged there. Equal operands and the most-negative-value cases probe the forced carry of 1 in subtract mode and the inversion of the carry-out into a borrow: getting either wrong leaves the result off by one or reports a borrow that did not happen. Multi-word sums and differences fed through carry_out to carry_in expose any mismatch in how carry-in and carry-out are treated between the two modes. Samples taken before the clock edge catch an output that is not really registered.

// File: rtl/csa_pkg.sv
package csa_pkg;
  // Pair of candidate carries: one assumes an incoming carry of 0, the other of 1.
  typedef struct packed {
    logic c0;
    logic c1;
  } cand_t;
endpackage

// File: rtl/csa_cell.sv
module csa_cell (
  input  logic a,
  input  logic b,
  input  logic cin0,
  input  logic cin1,
  output logic s0,
  output logic s1,
  output logic cout0,
  output logic cout1
);
  logic p;
  logic g;
  assign p     = a ^ b;
  assign g     = a & b;
  assign s0    = p ^ cin0;
  assign s1    = p ^ cin1;
  assign cout0 = g | (p & cin0);
  assign cout1 = g | (p & cin1);
endmodule

// File: rtl/csa_group.sv
module csa_group #(
  parameter int GW = 5
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          gcin,
  output logic [GW-1:0] s,
  output logic          gcout
);
  import csa_pkg::*;

  cand_t            chain [GW+1];
  logic  [GW-1:0]   s0;
  logic  [GW-1:0]   s1;

  assign chain[0].c0 = 1'b0;
  assign chain[0].c1 = 1'b1;

  for (genvar i = 0; i < GW; i++) begin : g_cell
    csa_cell u_cell (
      .a    (a[i]),
      .b    (b[i]),
      .cin0 (chain[i].c0),
      .cin1 (chain[i].c1),
      .s0   (s0[i]),
      .s1   (s1[i]),
      .cout0(chain[i+1].c0),
      .cout1(chain[i+1].c1)
    );
  end

  // The group carry-in picks one of the two precomputed chains.
  assign s     = gcin ? s1 : s0;
  assign gcout = gcin ? chain[GW].c1 : chain[GW].c0;
endmodule

// File: rtl/csa_slice.sv
module csa_slice #(
  parameter int W       = 10,
  parameter int GROUPS  = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry_out
);
  localparam int GW = W / GROUPS;

  logic [W-1:0]    b_eff;
  logic [W-1:0]    sum_c;
  logic [GROUPS:0] gcarry;
  logic            cout_c;

  // Subtraction: invert B and turn a zero borrow-in into a forced carry of 1.
  assign b_eff     = op_b ^ {W{sub}};
  assign gcarry[0] = carry_in ^ sub;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    csa_group #(.GW(GW)) u_grp (
      .a    (op_a[g*GW +: GW]),
      .b    (b_eff[g*GW +: GW]),
      .gcin (gcarry[g]),
      .s    (sum_c[g*GW +: GW]),
      .gcout(gcarry[g+1])
    );
  end

  // In subtract mode a carry of 0 out of the top means a borrow.
  assign cout_c = gcarry[GROUPS] ^ sub;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sum       <= '0;
        carry_out <= 1'b0;
      end else begin
        sum       <= sum_c;
        carry_out <= cout_c;
      end
    end
  end else begin : g_comb
    assign sum       = sum_c;
    assign carry_out = cout_c;
  end
endmodule

// File: rtl/csa_slice_chk.sv
module csa_slice_chk #(
  parameter int W       = 10,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         carry_in,
  input logic         sub,
  input logic [W-1:0] sum,
  input logic         carry_out
);
  logic [W:0] ref_add;
  logic [W:0] ref_sub;
  logic [W:0] ci_ext;

  always_comb begin
    ci_ext  = {{W{1'b0}}, carry_in};
    ref_add = {1'b0, op_a} + {1'b0, op_b} + ci_ext;
    ref_sub = {1'b0, op_a} - {1'b0, op_b} - ci_ext;
  end

  if (REG_OUT) begin : g_chk
    // R6
    a_r6_reset_clears: assert property (@(posedge clk)
      rst |=> (sum == '0 && !carry_out));
    // R1, R5
    a_r1_add_result: assert property (@(posedge clk) disable iff (rst)
      !sub |=> ({carry_out, sum} == $past(ref_add)));
    // R2, R5
    a_r2_sub_result: assert property (@(posedge clk) disable iff (rst)
      sub |=> ({carry_out, sum} == $past(ref_sub)));
    // R3
    a_r3_equal_zero: assert property (@(posedge clk) disable iff (rst)
      (sub && !carry_in && op_a == op_b) |=> (sum == '0 && !carry_out));
  end
endmodule

bind csa_slice csa_slice_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
  .sub(sub), .sum(sum), .carry_out(carry_out)
);

// File: tb/csa_slice_test.sv
module csa_slice_test;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         carry_in = 1'b0;
  logic         sub = 1'b0;
  logic [W-1:0] sum;
  logic         carry_out;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  csa_slice #(.W(W), .GROUPS(2), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sub(sub), .sum(sum), .carry_out(carry_out)
  );

  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic ci, input logic s);
    logic [W:0] r;
    if (s) r = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, ci};
    else   r = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    return r;
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the following falling edge.
  task automatic run(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic ci, input logic s);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci; sub = s;
    @(negedge clk);
    check(req, {carry_out, sum}, model(a, b, ci, s));
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_up();
  end

  initial begin
    logic [W:0]   prev;
    logic [2*W:0] exp_w;
    logic [W-1:0] lo_sum;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R6 reset state", {carry_out, sum}, '0);
    rst = 1'b0;

    // R4: carries across the group boundary and out of the slice
    run("R4 low group carry", 10'h01F, 10'h001, 1'b0, 1'b0);
    run("R4 all ones plus one", 10'h3FF, 10'h001, 1'b0, 1'b0);
    run("R4 carry_in ripple", 10'h3FF, 10'h000, 1'b1, 1'b0);
    run("R1 zero plus zero", 10'h000, 10'h000, 1'b0, 1'b0);
    run("R1 max plus max", 10'h3FF, 10'h3FF, 1'b1, 1'b0);
    // R3: forced LSB carry in subtract
    run("R3 equal operands", 10'h2A5, 10'h2A5, 1'b0, 1'b1);
    run("R3 equal zeros", 10'h000, 10'h000, 1'b0, 1'b1);
    run("R3 equal ones", 10'h3FF, 10'h3FF, 1'b0, 1'b1);
    // R8: most negative value
    run("R8 most negative minus one", 10'h200, 10'h001, 1'b0, 1'b1);
    run("R8 zero minus most negative", 10'h000, 10'h200, 1'b0, 1'b1);
    run("R2 zero minus one", 10'h000, 10'h001, 1'b0, 1'b1);
    run("R2 borrow in", 10'h005, 10'h005, 1'b1, 1'b1);

    // R5: output holds before the edge, updates after it
    run("R5 setup", 10'h123, 10'h045, 1'b0, 1'b0);
    prev = model(10'h123, 10'h045, 1'b0, 1'b0);
    @(negedge clk);
    op_a = 10'h300; op_b = 10'h100; carry_in = 1'b0; sub = 1'b0;
    #1;
    check("R5 no change before edge", {carry_out, sum}, prev);
    @(negedge clk);
    check("R5 result after edge", {carry_out, sum}, {1'b1, 10'h000});

    // R6: reset mid-run
    run("R6 nonzero before reset", 10'h0F0, 10'h00F, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R6 reset clears", {carry_out, sum}, '0);
    rst = 1'b0;

    // R1/R2 random
    for (int i = 0; i < 1500; i++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic ci;
      logic s;
      a  = W'($urandom);
      b  = W'($urandom);
      ci = 1'($urandom);
      s  = 1'($urandom);
      run(s ? "R2 random sub" : "R1 random add", a, b, ci, s);
    end

    // R7: two-word cascade through carry_out -> carry_in
    for (int i = 0; i < 200; i++) begin
      logic [2*W-1:0] x;
      logic [2*W-1:0] y;
      logic s;
      x = (2*W)'($urandom);
      y = (2*W)'($urandom);
      if (i == 0) begin x = '1; y = 1; end
      if (i == 1) begin x = 0; y = 1; end
      s = (i == 0) ? 1'b0 : (i == 1) ? 1'b1 : 1'($urandom);
      if (s) exp_w = {1'b0, x} - {1'b0, y};
      else   exp_w = {1'b0, x} + {1'b0, y};
      @(negedge clk);
      op_a = x[W-1:0]; op_b = y[W-1:0]; carry_in = 1'b0; sub = s;
      @(negedge clk);
      lo_sum = sum;
      op_a = x[2*W-1:W]; op_b = y[2*W-1:W]; carry_in = carry_out; sub = s;
      @(negedge clk);
      check("R7 cascade", {carry_out, sum, lo_sum}, exp_w);
    end

    finish_up();
  end
endmodule